// File: doc/BRIEF.md
# Symmetric Plane-Rotation Update Engine

This block performs one step of a cyclic Jacobi eigen-solver. Given an index pair (i, j) with i < j and a precomputed cosine/sine pair, it rewrites a symmetric matrix held in an external RAM as M' = Jᵀ·M·J. J is the identity except at four places: (i,i) = c, (j,j) = c, (i,j) = s and (j,i) = −s. In the same step it post-multiplies an external eigenvector matrix by J. Another unit chooses the pair and produces the angle. A further unit counts sweeps.

Both RAMs hold one matrix row per address. Lane k of a row sits at bits [18k+17:18k]. Each RAM has a synchronous read port with one cycle of latency, and a write port with a per-lane write mask. The engine first rewrites rows i and j from a buffered copy of row i and the freshly read row j. It then streams every active row once: it rotates the entries in columns i and j and writes them back, and it streams the eigenvector rows at the same addresses. A size select limits all work to a 4×4 corner of the 8×8 store. A first-rotation flag makes the engine treat the eigenvector store as the identity, so no separate clear pass is needed.

Top module: `jacobi_rot_update`

## Requirements
- R1: After one operation the matrix store holds the result of two steps done in this order. The row step, for every active k: m_ik ← c·m_ik − s·m_jk, then m_jk ← s·m_ik + c·m_jk, using the old values. The column step then applies the same form to (m_ki, m_kj) for every active row k, on the row-step result.
- R2: Entries outside rows i and j and columns i and j are never written. A write mask is either the two lanes i and j, or every active lane.
- R3: Every result equals (p + 2^13) >> 14, an arithmetic shift, where p is the full-precision two-product sum of 1.3.14 operands.
- R4: A rounded result above 131071 becomes 131071, and one below −131072 becomes −131072.
- R5: With ev_first low, for every active row k, eigenvector entries (k,i) and (k,j) become c·e_ki − s·e_kj and s·e_ki + c·e_kj. No other eigenvector entry changes.
- R6: With ev_first high, the old eigenvector contents are replaced by the identity times J. Every active lane of every active row is written, with 16384 (1.0) on the diagonal and 0 elsewhere before the rotation.
- R7: With size4 high, only rows 0–3 and lanes 0–3 of either store are written. Rows and lanes 4–7 keep their contents.
- R8: done is high for exactly one cycle, N+6 cycles after the edge that accepts start (N = 4 or 8). This is the cycle after the last write.
- R9: Reads return lane k of the addressed row at bits [18k+17:18k] one cycle after the read enable. Writes change only the lanes whose mask bit is set.
- R10: start is accepted only while idle. A start pulse during an operation changes neither the result nor the done timing. While idle, no read or write enable is raised.
- R11: After reset, done and all read and write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one rotation (taken only when idle) |
| size4 | input | 1 | 1: operate on the 4×4 corner, 0: full 8×8 |
| ev_first | input | 1 | Treat eigenvector store as identity for this rotation |
| idx_i | input | 3 | Lower index of the rotation plane |
| idx_j | input | 3 | Upper index of the rotation plane |
| cos_in | input | 18 | Cosine, signed 1.3.14 |
| sin_in | input | 18 | Sine, signed 1.3.14 |
| mat_rd_en | output | 1 | Matrix RAM read enable |
| mat_rd_addr | output | 3 | Matrix RAM read row |
| mat_rd_data | input | 144 | Matrix RAM read row data (8 lanes) |
| mat_wr_en | output | 1 | Matrix RAM write enable |
| mat_wr_addr | output | 3 | Matrix RAM write row |
| mat_wr_mask | output | 8 | Matrix RAM per-lane write mask |
| mat_wr_data | output | 144 | Matrix RAM write row data |
| ev_rd_en | output | 1 | Eigenvector RAM read enable |
| ev_rd_addr | output | 3 | Eigenvector RAM read row |
| ev_rd_data | input | 144 | Eigenvector RAM read row data |
| ev_wr_en | output | 1 | Eigenvector RAM write enable |
| ev_wr_addr | output | 3 | Eigenvector RAM write row |
| ev_wr_mask | output | 8 | Eigenvector RAM per-lane write mask |
| ev_wr_data | output | 144 | Eigenvector RAM write row data |
| done | output | 1 | One-cycle completion pulse |

## Verification
During the column stream, two things happen in one cycle: the write-back of row k and the read of row k+1 in the matrix store. The eigenvector write of the same row also coincides with the matrix write. Every full-size and 4×4 operation provokes this overlap. The bench models the RAMs with one-cycle reads and masked writes, and compares every entry of both stores against a bench model that applies the row step and then the column step. A missed write, a stale read or a lane written to the wrong store shows up as a mismatched entry. A start pulse injected mid-operation checks that the overlap is not disturbed.

// File: rtl/jrot_pkg.sv
package jrot_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_I,
      ST_RD_J,
      ST_WR_I,
      ST_WR_J,
      ST_COL,
      ST_FIN
   } jrot_state_e;

endpackage

// File: rtl/jr_rot_pair.sv
// One rotation lane: x = c*a - s*b, y = s*a + c*b, rounded and saturated.
module jr_rot_pair #(
   parameter int W    = 18,
   parameter int FRAC = 14
) (
   input  logic signed [W-1:0] c,
   input  logic signed [W-1:0] s,
   input  logic signed [W-1:0] a,
   input  logic signed [W-1:0] b,
   output logic signed [W-1:0] x,
   output logic signed [W-1:0] y
);
   localparam int PW = 2 * W + 2;
   localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (FRAC - 1));
   localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (W - 1)) - 64'sd1);
   localparam logic signed [PW-1:0] MINV = PW'(-(64'sd1 <<< (W - 1)));

   logic signed [2*W-1:0] ca, sb, sa, cb;
   logic signed [PW-1:0]  sx, sy, tx, ty;

   assign ca = c * a;
   assign sb = s * b;
   assign sa = s * a;
   assign cb = c * b;

   assign sx = {{2{ca[2*W-1]}}, ca} - {{2{sb[2*W-1]}}, sb};
   assign sy = {{2{sa[2*W-1]}}, sa} + {{2{cb[2*W-1]}}, cb};

   assign tx = (sx + HALF) >>> FRAC;
   assign ty = (sy + HALF) >>> FRAC;

   function automatic logic signed [W-1:0] clip(input logic signed [PW-1:0] v);
      if (v > MAXV)      return MAXV[W-1:0];
      else if (v < MINV) return MINV[W-1:0];
      else               return v[W-1:0];
   endfunction

   assign x = clip(tx);
   assign y = clip(ty);

endmodule

// File: rtl/jr_row_merge.sv
// Replaces lanes sel_i and sel_j of a packed row and reports their mask.
module jr_row_merge #(
   parameter int W    = 18,
   parameter int NMAX = 8,
   localparam int AW  = $clog2(NMAX),
   localparam int RW  = NMAX * W
) (
   input  logic [RW-1:0]       base_row,
   input  logic [AW-1:0]       sel_i,
   input  logic [AW-1:0]       sel_j,
   input  logic signed [W-1:0] val_i,
   input  logic signed [W-1:0] val_j,
   output logic [RW-1:0]       out_row,
   output logic [NMAX-1:0]     pair_mask
);
   for (genvar l = 0; l < NMAX; l++) begin : g_lane
      logic hit_i, hit_j;
      assign hit_i = (sel_i == AW'(l));
      assign hit_j = (sel_j == AW'(l));
      assign pair_mask[l] = hit_i | hit_j;
      assign out_row[l*W +: W] = hit_i ? val_i :
                                 hit_j ? val_j : base_row[l*W +: W];
   end

endmodule

// File: rtl/jr_ctrl.sv
// Sequencer: row read/write phase, then a pipelined column stream.
module jr_ctrl
   import jrot_pkg::*;
#(
   parameter int NMAX = 8,
   localparam int AW  = $clog2(NMAX),
   localparam int NW  = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NW-1:0]     n_act,
   input  logic [AW-1:0]     idx_i,
   input  logic [AW-1:0]     idx_j,
   output jrot_state_e       state,
   output logic              busy,
   output logic              rd_en,
   output logic [AW-1:0]     rd_addr,
   output logic [AW-1:0]     wr_addr,
   output logic              col_wr,
   output logic              done
);
   jrot_state_e   st_q, st_d;
   logic [NW-1:0] rk_q;
   logic [AW-1:0] wk_q;
   logic          pend_q;

   always_comb begin
      st_d    = st_q;
      rd_en   = 1'b0;
      rd_addr = idx_i;
      wr_addr = wk_q;
      done    = 1'b0;
      unique case (st_q)
         ST_IDLE: if (start) st_d = ST_RD_I;
         ST_RD_I: begin
            rd_en   = 1'b1;
            rd_addr = idx_i;
            st_d    = ST_RD_J;
         end
         ST_RD_J: begin
            rd_en   = 1'b1;
            rd_addr = idx_j;
            st_d    = ST_WR_I;
         end
         ST_WR_I: begin
            wr_addr = idx_i;
            st_d    = ST_WR_J;
         end
         ST_WR_J: begin
            wr_addr = idx_j;
            st_d    = ST_COL;
         end
         ST_COL: begin
            rd_en   = (rk_q < n_act);
            rd_addr = rk_q[AW-1:0];
            if (!(rk_q < n_act)) st_d = ST_FIN;
         end
         ST_FIN: begin
            done = 1'b1;
            st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         rk_q   <= '0;
         wk_q   <= '0;
         pend_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q != ST_COL) begin
            rk_q   <= '0;
            pend_q <= 1'b0;
         end else begin
            pend_q <= rd_en;
            wk_q   <= rk_q[AW-1:0];
            if (rd_en) rk_q <= rk_q + 1'b1;
         end
      end
   end

   assign state  = st_q;
   assign busy   = (st_q != ST_IDLE);
   assign col_wr = (st_q == ST_COL) && pend_q;

endmodule

// File: rtl/jacobi_rot_update.sv
module jacobi_rot_update
   import jrot_pkg::*;
#(
   parameter int W      = 18,
   parameter int FRAC   = 14,
   parameter int NMAX   = 8,
   parameter int NSMALL = 4,
   localparam int AW    = $clog2(NMAX),
   localparam int RW    = NMAX * W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              size4,
   input  logic              ev_first,
   input  logic [AW-1:0]     idx_i,
   input  logic [AW-1:0]     idx_j,
   input  logic signed [W-1:0] cos_in,
   input  logic signed [W-1:0] sin_in,
   output logic              mat_rd_en,
   output logic [AW-1:0]     mat_rd_addr,
   input  logic [RW-1:0]     mat_rd_data,
   output logic              mat_wr_en,
   output logic [AW-1:0]     mat_wr_addr,
   output logic [NMAX-1:0]   mat_wr_mask,
   output logic [RW-1:0]     mat_wr_data,
   output logic              ev_rd_en,
   output logic [AW-1:0]     ev_rd_addr,
   input  logic [RW-1:0]     ev_rd_data,
   output logic              ev_wr_en,
   output logic [AW-1:0]     ev_wr_addr,
   output logic [NMAX-1:0]   ev_wr_mask,
   output logic [RW-1:0]     ev_wr_data,
   output logic              done
);
   localparam int NW = AW + 1;

   // elaboration-time parameter checks
   if (W < FRAC + 2) begin : g_bad_width
      $error("jacobi_rot_update: W must leave sign and integer bits above FRAC");
   end
   if (NMAX < 4 || (1 << AW) != NMAX) begin : g_bad_nmax
      $error("jacobi_rot_update: NMAX must be a power of two of at least 4");
   end
   if (NSMALL < 2 || NSMALL > NMAX) begin : g_bad_nsmall
      $error("jacobi_rot_update: NSMALL must lie in 2..NMAX");
   end

   localparam logic signed [W-1:0] ONE = {{(W-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};

   // operands captured at acceptance
   logic [AW-1:0]       q_i, q_j;
   logic signed [W-1:0] q_c, q_s;
   logic                q_m4, q_first;

   jrot_state_e   state;
   logic          busy, rd_en, col_wr;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [NW-1:0] n_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_i     <= '0;
         q_j     <= '0;
         q_c     <= '0;
         q_s     <= '0;
         q_m4    <= 1'b0;
         q_first <= 1'b0;
      end else if (start && !busy) begin
         q_i     <= idx_i;
         q_j     <= idx_j;
         q_c     <= cos_in;
         q_s     <= sin_in;
         q_m4    <= size4;
         q_first <= ev_first;
      end
   end

   assign n_act = q_m4 ? NW'(NSMALL) : NW'(NMAX);

   jr_ctrl #(.NMAX(NMAX)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .n_act   (n_act),
      .idx_i   (q_i),
      .idx_j   (q_j),
      .state   (state),
      .busy    (busy),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .wr_addr (wr_addr),
      .col_wr  (col_wr),
      .done    (done)
   );

   // lane views of the read buses, active-lane mask, identity row
   logic signed [W-1:0] mrd [NMAX];
   logic signed [W-1:0] erd [NMAX];
   logic [NMAX-1:0]     act_mask;
   logic [RW-1:0]       id_row;

   for (genvar l = 0; l < NMAX; l++) begin : g_view
      assign mrd[l]            = mat_rd_data[l*W +: W];
      assign erd[l]            = ev_rd_data[l*W +: W];
      assign act_mask[l]       = (NW'(l) < n_act);
      assign id_row[l*W +: W]  = (wr_addr == AW'(l)) ? ONE : '0;
   end

   // buffered row i (row pass) and pending rotated row j
   logic [RW-1:0] row_i_q, row_jn_q;
   logic [RW-1:0] rx_row, ry_row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_i_q  <= '0;
         row_jn_q <= '0;
      end else begin
         if (state == ST_RD_J) row_i_q  <= mat_rd_data;
         if (state == ST_WR_I) row_jn_q <= ry_row;
      end
   end

   // column-pass operands: matrix uses lane 0, eigenvectors use lane 1
   logic signed [W-1:0] col_ma, col_mb, col_ea, col_eb;
   assign col_ma = mrd[q_i];
   assign col_mb = mrd[q_j];
   assign col_ea = q_first ? ((wr_addr == q_i) ? ONE : '0) : erd[q_i];
   assign col_eb = q_first ? ((wr_addr == q_j) ? ONE : '0) : erd[q_j];

   logic signed [W-1:0] rx [NMAX];
   logic signed [W-1:0] ry [NMAX];

   for (genvar l = 0; l < NMAX; l++) begin : g_lane
      logic signed [W-1:0] op_a, op_b;
      if (l == 0) begin : g_mat_share
         assign op_a = (state == ST_COL) ? col_ma : row_i_q[l*W +: W];
         assign op_b = (state == ST_COL) ? col_mb : mrd[l];
      end else if (l == 1) begin : g_ev_share
         assign op_a = (state == ST_COL) ? col_ea : row_i_q[l*W +: W];
         assign op_b = (state == ST_COL) ? col_eb : mrd[l];
      end else begin : g_row_only
         assign op_a = row_i_q[l*W +: W];
         assign op_b = mrd[l];
      end
      jr_rot_pair #(.W(W), .FRAC(FRAC)) u_rot (
         .c (q_c),
         .s (q_s),
         .a (op_a),
         .b (op_b),
         .x (rx[l]),
         .y (ry[l])
      );
      assign rx_row[l*W +: W] = rx[l];
      assign ry_row[l*W +: W] = ry[l];
   end

   // column-pass merges
   logic [RW-1:0]   mat_merged, ev_merged, ev_base;
   logic [NMAX-1:0] mat_pair, ev_pair;

   assign ev_base = q_first ? id_row : ev_rd_data;

   jr_row_merge #(.W(W), .NMAX(NMAX)) u_mat_merge (
      .base_row  (mat_rd_data),
      .sel_i     (q_i),
      .sel_j     (q_j),
      .val_i     (rx[0]),
      .val_j     (ry[0]),
      .out_row   (mat_merged),
      .pair_mask (mat_pair)
   );

   jr_row_merge #(.W(W), .NMAX(NMAX)) u_ev_merge (
      .base_row  (ev_base),
      .sel_i     (q_i),
      .sel_j     (q_j),
      .val_i     (rx[1]),
      .val_j     (ry[1]),
      .out_row   (ev_merged),
      .pair_mask (ev_pair)
   );

   // RAM ports
   assign mat_rd_en   = rd_en;
   assign mat_rd_addr = rd_addr;
   assign mat_wr_en   = (state == ST_WR_I) || (state == ST_WR_J) || col_wr;
   assign mat_wr_addr = wr_addr;
   assign mat_wr_mask = col_wr ? mat_pair : act_mask;
   assign mat_wr_data = (state == ST_WR_I) ? rx_row :
                        (state == ST_WR_J) ? row_jn_q : mat_merged;

   assign ev_rd_en    = rd_en && (state == ST_COL);
   assign ev_rd_addr  = rd_addr;
   assign ev_wr_en    = col_wr;
   assign ev_wr_addr  = wr_addr;
   assign ev_wr_mask  = q_first ? act_mask : ev_pair;
   assign ev_wr_data  = ev_merged;

endmodule

// File: rtl/jrot_checker.sv
module jrot_checker #(
   parameter int NMAX   = 8,
   parameter int NSMALL = 4,
   localparam int AW    = $clog2(NMAX)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            size4,
   input logic            busy,
   input logic            done,
   input logic            mat_rd_en,
   input logic            mat_wr_en,
   input logic [AW-1:0]   mat_wr_addr,
   input logic [NMAX-1:0] mat_wr_mask,
   input logic            ev_wr_en,
   input logic [AW-1:0]   ev_wr_addr,
   input logic [NMAX-1:0] ev_wr_mask
);
   logic m4_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                m4_q <= 1'b0;
      else if (start && !busy)   m4_q <= size4;
   end

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mat_wr_en));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mat_wr_en && !ev_wr_en && !mat_rd_en));

   p_small_mat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (m4_q && mat_wr_en) |-> ((int'(mat_wr_addr) < NSMALL) && ((mat_wr_mask >> NSMALL) == '0)));

   p_small_ev_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (m4_q && ev_wr_en) |-> ((int'(ev_wr_addr) < NSMALL) && ((ev_wr_mask >> NSMALL) == '0)));

   p_mask_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mat_wr_en |-> (($countones(mat_wr_mask) == 2) ||
                     ($countones(mat_wr_mask) == (m4_q ? NSMALL : NMAX))));

   p_ev_with_mat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_wr_en |-> (mat_wr_en && (ev_wr_addr == mat_wr_addr)));

endmodule

bind jacobi_rot_update jrot_checker #(.NMAX(NMAX), .NSMALL(NSMALL)) u_jrot_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .size4       (size4),
   .busy        (busy),
   .done        (done),
   .mat_rd_en   (mat_rd_en),
   .mat_wr_en   (mat_wr_en),
   .mat_wr_addr (mat_wr_addr),
   .mat_wr_mask (mat_wr_mask),
   .ev_wr_en    (ev_wr_en),
   .ev_wr_addr  (ev_wr_addr),
   .ev_wr_mask  (ev_wr_mask)
);

// File: tb/jacobi_rot_update_tb.sv
module jacobi_rot_update_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W    = 18;
   localparam int FRAC = 14;
   localparam int NMAX = 8;
   localparam int AW   = 3;
   localparam int RW   = NMAX * W;
   localparam int ONE  = 16384;
   localparam int VMAX = 131071;
   localparam int VMIN = -131072;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic            rst_n, start, size4, ev_first;
   logic [AW-1:0]   idx_i, idx_j;
   logic signed [W-1:0] cos_in, sin_in;
   logic            mat_rd_en, mat_wr_en, ev_rd_en, ev_wr_en, done;
   logic [AW-1:0]   mat_rd_addr, mat_wr_addr, ev_rd_addr, ev_wr_addr;
   logic [RW-1:0]   mat_rd_data, mat_wr_data, ev_rd_data, ev_wr_data;
   logic [NMAX-1:0] mat_wr_mask, ev_wr_mask;

   int tests = 0;
   int fails = 0;
   int mem [8][8];
   int ev  [8][8];

   jacobi_rot_update dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .size4(size4), .ev_first(ev_first),
      .idx_i(idx_i), .idx_j(idx_j), .cos_in(cos_in), .sin_in(sin_in),
      .mat_rd_en(mat_rd_en), .mat_rd_addr(mat_rd_addr), .mat_rd_data(mat_rd_data),
      .mat_wr_en(mat_wr_en), .mat_wr_addr(mat_wr_addr), .mat_wr_mask(mat_wr_mask),
      .mat_wr_data(mat_wr_data),
      .ev_rd_en(ev_rd_en), .ev_rd_addr(ev_rd_addr), .ev_rd_data(ev_rd_data),
      .ev_wr_en(ev_wr_en), .ev_wr_addr(ev_wr_addr), .ev_wr_mask(ev_wr_mask),
      .ev_wr_data(ev_wr_data), .done(done)
   );

   // RAM models (R9): one row per address, lane k at [18k+17:18k], 1-cycle read
   always @(posedge clk) begin
      if (mat_rd_en)
         for (int l = 0; l < NMAX; l++) mat_rd_data[l*W +: W] <= W'(mem[mat_rd_addr][l]);
      if (ev_rd_en)
         for (int l = 0; l < NMAX; l++) ev_rd_data[l*W +: W] <= W'(ev[ev_rd_addr][l]);
      if (mat_wr_en)
         for (int l = 0; l < NMAX; l++)
            if (mat_wr_mask[l]) mem[mat_wr_addr][l] <= int'($signed(mat_wr_data[l*W +: W]));
      if (ev_wr_en)
         for (int l = 0; l < NMAX; l++)
            if (ev_wr_mask[l]) ev[ev_wr_addr][l] <= int'($signed(ev_wr_data[l*W +: W]));
   end

   // R3/R4 reference: round half up by adding 2^13, shift 14, clip
   function automatic int rsat(longint p);
      longint r;
      r = (p + 64'sd8192) >>> FRAC;
      if (r > VMAX) return VMAX;
      if (r < VMIN) return VMIN;
      return int'(r);
   endfunction

   function automatic int rot_x(int c, int s, int a, int b);
      return rsat(longint'(c) * longint'(a) - longint'(s) * longint'(b));
   endfunction

   function automatic int rot_y(int c, int s, int a, int b);
      return rsat(longint'(s) * longint'(a) + longint'(c) * longint'(b));
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic fill_sym(int lo, int hi);
      for (int r = 0; r < 8; r++)
         for (int k = r; k < 8; k++) begin
            int v;
            v = int'($urandom_range(hi - lo)) + lo;
            mem[r][k] = v;
            mem[k][r] = v;
         end
   endtask

   task automatic fill_ev();
      for (int r = 0; r < 8; r++)
         for (int k = 0; k < 8; k++)
            ev[r][k] = int'($urandom_range(65535)) - 32768;
   endtask

   task automatic run_rot(int i, int j, int c, int s, bit m4, bit first, bit poke, string tag);
      int n, cnt;
      int em [8][8];
      int ee [8][8];
      int a, b;
      int bad_m, bad_e, am, xm, ae, xe;
      n  = m4 ? 4 : 8;
      em = mem;
      ee = ev;
      for (int k = 0; k < n; k++) begin
         a = em[i][k]; b = em[j][k];
         em[i][k] = rot_x(c, s, a, b);
         em[j][k] = rot_y(c, s, a, b);
      end
      for (int k = 0; k < n; k++) begin
         a = em[k][i]; b = em[k][j];
         em[k][i] = rot_x(c, s, a, b);
         em[k][j] = rot_y(c, s, a, b);
         if (first)
            for (int l = 0; l < n; l++) ee[k][l] = (l == k) ? ONE : 0;
         a = ee[k][i]; b = ee[k][j];
         ee[k][i] = rot_x(c, s, a, b);
         ee[k][j] = rot_y(c, s, a, b);
      end

      @(negedge clk);
      idx_i = AW'(i); idx_j = AW'(j);
      cos_in = W'(c); sin_in = W'(s);
      size4 = m4; ev_first = first;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt = 1;
      while (done !== 1'b1 && cnt < 40) begin
         if (poke && cnt == 3) begin
            // R10: start while busy with different operands
            start = 1'b1;
            idx_i = AW'(j); idx_j = AW'(i);
            size4 = ~m4; ev_first = ~first;
            cos_in = W'(s); sin_in = W'(c);
         end
         @(negedge clk);
         start = 1'b0;
         cnt++;
      end
      check(cnt == n + 6, {tag, " R8"}, "done latency", cnt, n + 6);
      @(negedge clk);
      check(done == 1'b0, {tag, " R8"}, "done width", int'(done), 0);

      bad_m = 0; bad_e = 0; am = 0; xm = 0; ae = 0; xe = 0;
      for (int r = 0; r < 8; r++)
         for (int k = 0; k < 8; k++) begin
            if (mem[r][k] != em[r][k] && bad_m == 0) begin
               bad_m = 1; am = mem[r][k]; xm = em[r][k];
               $display("  matrix mismatch at (%0d,%0d)", r, k);
            end
            if (ev[r][k] != ee[r][k] && bad_e == 0) begin
               bad_e = 1; ae = ev[r][k]; xe = ee[r][k];
               $display("  eigvec mismatch at (%0d,%0d)", r, k);
            end
         end
      check(bad_m == 0, {tag, " R1 R2 R9"}, "matrix entry", am, xm);
      check(bad_e == 0, {tag, first ? " R6" : " R5"}, "eigvec entry", ae, xe);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int c, s, i, j;
      real th;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; start = 1'b0; size4 = 1'b0; ev_first = 1'b0;
      idx_i = '0; idx_j = '0; cos_in = '0; sin_in = '0;
      mat_rd_data = '0; ev_rd_data = '0;
      for (int r = 0; r < 8; r++)
         for (int k = 0; k < 8; k++) begin mem[r][k] = 0; ev[r][k] = 0; end
      repeat (3) @(negedge clk);
      // R11 reset state
      check(done == 1'b0, "R11", "done in reset", int'(done), 0);
      check(mat_wr_en == 1'b0 && ev_wr_en == 1'b0, "R11", "write enables in reset",
            int'(mat_wr_en) + int'(ev_wr_en), 0);
      check(mat_rd_en == 1'b0 && ev_rd_en == 1'b0, "R11", "read enables in reset",
            int'(mat_rd_en) + int'(ev_rd_en), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(mat_rd_en == 1'b0 && mat_wr_en == 1'b0, "R10", "idle quiet",
            int'(mat_rd_en) + int'(mat_wr_en), 0);

      // R3 rounding ties and near-ties: c = 1 LSB, s = 0
      for (int r = 0; r < 8; r++)
         for (int k = 0; k < 8; k++)
            mem[r][k] = ((r + k) % 3 == 0) ? 8192 : (((r + k) % 3 == 1) ? -8192 : 8191);
      fill_ev();
      run_rot(0, 1, 1, 0, 1'b0, 1'b0, 1'b0, "R3");
      fill_sym(-16384, 16384);
      run_rot(2, 5, 3, -16384, 1'b0, 1'b0, 1'b0, "R3");

      // R4 saturation both signs
      for (int r = 0; r < 8; r++)
         for (int k = 0; k < 8; k++) mem[r][k] = 129434;
      run_rot(1, 6, 11585, 11585, 1'b0, 1'b1, 1'b0, "R4");
      for (int r = 0; r < 8; r++)
         for (int k = 0; k < 8; k++) mem[r][k] = -129434;
      run_rot(3, 4, 11585, 11585, 1'b0, 1'b0, 1'b0, "R4");

      // R6 identity start, full size and 4x4
      fill_sym(-32768, 32768); fill_ev();
      run_rot(0, 7, 14189, 8192, 1'b0, 1'b1, 1'b0, "R6");
      fill_sym(-32768, 32768); fill_ev();
      run_rot(1, 3, 15137, -6270, 1'b1, 1'b1, 1'b0, "R6 R7");

      // R7 4x4 without identity start, upper rows/lanes hold random data
      fill_sym(-65536, 65536); fill_ev();
      run_rot(0, 3, 12540, 10531, 1'b1, 1'b0, 1'b0, "R7");

      // R10 start pulse during operation is ignored
      fill_sym(-32768, 32768); fill_ev();
      run_rot(2, 6, 9830, -13107, 1'b0, 1'b0, 1'b1, "R10");
      fill_sym(-32768, 32768);
      run_rot(0, 2, 16000, 3535, 1'b1, 1'b0, 1'b1, "R10 R7");

      // constrained random sequence of rotations on an evolving matrix
      fill_sym(-32768, 32768); fill_ev();
      for (int t = 0; t < 10; t++) begin
         bit m4;
         int n;
         m4 = ($urandom_range(3) == 0);
         n  = m4 ? 4 : 8;
         i  = int'($urandom_range(n - 2));
         j  = int'($urandom_range(n - 1, i + 1));
         th = real'($urandom_range(6283)) / 1000.0;
         c  = int'($cos(th) * 16384.0);
         s  = int'($sin(th) * 16384.0);
         run_rot(i, j, c, s, m4, (t == 0), 1'b0, "R1 rand");
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule